// File: doc/BRIEF.md
# Two-Channel DMA Request Arbiter and Transfer Sequencer

This block decides when a direct-memory-access bus cycle may begin and then paces it. Each channel raises a request line; the request is brought into the clock domain, weighed against the other channel by a programmable priority, and turned into a transfer. The transfer is a fetch phase and then a deposit phase. Destination-paced channels add a short settle phase after the deposit. Bus strobes for each phase and a one-hot grant tell the surrounding bus logic what to run and for which channel.

The block always yields to the rest of the system. An external bus-hold request, or a CPU bus lock, keeps any new DMA bus cycle from starting for as long as it lasts. Address generation, transfer counters and the bus interface sit outside the block. The only thing they send back is a per-channel "count reached" input, which stops a free-running channel.

Top module: `dma_req_sequencer`

## Requirements
- R1: While reset is held and in the cycle after it ends, fetchStb, depositStb, settleStb, xferWord and chGrant are all zero.
- R2: No fetch phase starts in a cycle that follows a cycle with holdReq high; a request made while holdReq is high starts its fetch two clocks after holdReq drops.
- R3: No fetch phase starts in a cycle that follows a cycle with busLock high, however long the lock lasts; the request stays pending and starts two clocks after the lock drops.
- R4: Channel i takes its priority from chPrio[i*PRIO_W +: PRIO_W], and a larger value wins. When both channels request, the higher one is served first and the other starts its transfer afterwards.
- R5: When requesting channels have equal priority, service rotates: the channel after the one most recently served goes first (after reset, channel 0).
- R6: With the sequencer idle and unblocked, fetchStb rises exactly four clocks after a request is first sampled high.
- R7: The mode of channel i is chMode[2i +: 2]: 0 free-running, 1 or 3 source-paced, 2 destination-paced. Every transfer drives fetchStb for four clocks, immediately followed by depositStb for four clocks.
- R8: A destination-paced transfer follows its deposit with exactly two clocks of settleStb; other modes have no settle clocks.
- R9: When byteBus is 1, phase timing is unchanged and xferWord stays 0; when byteBus is 0, xferWord is 1 in every fetch and deposit clock.
- R10: After a destination-paced transfer, a request level seen only during its deposit or settle clocks does not start a new transfer; a request still high after the settle phase starts a new fetch four clocks after settleStb falls.
- R11: A free-running channel starts its next fetch in the clock right after its deposit, unless its chDone input is high in the last deposit clock; in that case the sequencer goes idle.
- R12: chGrant is one-hot for the served channel during fetch, deposit and settle clocks, stays constant throughout them, and is zero at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chReq | input | NCH | Per-channel transfer request, asynchronous |
| chPrio | input | NCH*PRIO_W | Per-channel priority, larger wins |
| chMode | input | 2*NCH | Per-channel pacing mode |
| chDone | input | NCH | Per-channel transfer count reached |
| holdReq | input | 1 | External bus-hold request |
| busLock | input | 1 | CPU bus lock |
| byteBus | input | 1 | 1 selects an 8-bit data bus |
| fetchStb | output | 1 | Fetch phase active |
| depositStb | output | 1 | Deposit phase active |
| settleStb | output | 1 | Settle (idle) phase active |
| xferWord | output | 1 | Current phase moves a 16-bit word |
| chGrant | output | NCH | One-hot served channel |

## Verification
The bench builds the block with its defaults: two channels, two-bit priorities, a two-stage synchronizer and phase lengths of four, four and two clocks. With these values the four-clock latency, the eight- and ten-clock transfers and the two-way round-robin are exact numbers that the bench can check. Two-bit priorities let a single vector table cover a higher channel 0, a higher channel 1 and equal priorities. The same table switches the bus width and the pacing mode, and directed runs cover hold, lock, the resample rule and free-running chains.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    MODE_FREE    = 2'd0,
    MODE_SRC     = 2'd1,
    MODE_DST     = 2'd2,
    MODE_SRC_ALT = 2'd3
  } xferMode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRIO,
    ST_FETCH,
    ST_DEPOSIT,
    ST_SETTLE
  } seqState_e;

  // strobes from the sequencer control to the channel datapath
  typedef struct packed {
    logic capture;  // latch the arbitration winner
    logic flush;    // clear the served channel's synchronizer
    logic fetch;
    logic deposit;
    logic settle;
  } ctlStb_t;

endpackage

// File: rtl/dma_seq_sync.sv
module dma_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic flush,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rstN || flush) pipe <= '0;
    else                pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/dma_seq_datapath.sv
module dma_seq_datapath
  import dma_seq_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int PRIO_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NCH-1:0]        chReq,
  input  logic [NCH*PRIO_W-1:0] chPrio,
  input  logic [2*NCH-1:0]      chMode,
  input  logic [NCH-1:0]        chDone,
  input  ctlStb_t               ctl,
  output logic                  anyElig,
  output xferMode_e             curMode,
  output logic                  curDone,
  output logic [NCH-1:0]        chGrant
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0]    reqSync;
  logic [NCH-1:0]    flushVec;
  logic [PRIO_W-1:0] prioArr [NCH];
  xferMode_e         modeArr [NCH];
  logic [CH_W-1:0]   curCh, rrPtr, winner, scanIdx;
  logic              found;
  logic [PRIO_W-1:0] bestPrio;
  logic              beaten;
  logic              active;

  assign flushVec = ctl.flush ? (NCH'(1) << curCh) : '0;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_seq_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rstN (rstN),
      .flush(flushVec[i]),
      .din  (chReq[i]),
      .dout (reqSync[i])
    );
    assign prioArr[i] = chPrio[i*PRIO_W +: PRIO_W];
    assign modeArr[i] = xferMode_e'(chMode[2*i +: 2]);
  end

  assign anyElig = |reqSync;

  // scan from the channel after the last one served; strict compare keeps
  // the earliest channel in rotation order on a priority tie
  always_comb begin
    winner   = rrPtr;
    found    = 1'b0;
    bestPrio = '0;
    scanIdx  = '0;
    for (int off = 1; off <= NCH; off++) begin
      scanIdx = CH_W'((int'(rrPtr) + off) % NCH);
      if (reqSync[scanIdx] && (!found || prioArr[scanIdx] > bestPrio)) begin
        found    = 1'b1;
        winner   = scanIdx;
        bestPrio = prioArr[scanIdx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCh <= '0;
      rrPtr <= CH_W'(NCH - 1);
    end else if (ctl.capture) begin
      curCh <= winner;
      rrPtr <= winner;
    end
  end

  assign curMode = modeArr[curCh];
  assign curDone = chDone[curCh];
  assign active  = ctl.fetch | ctl.deposit | ctl.settle;
  assign chGrant = active ? (NCH'(1) << curCh) : '0;

  // checker-side view: did any eligible channel outrank the winner?
  always_comb begin
    beaten = 1'b0;
    for (int k = 0; k < NCH; k++)
      if (reqSync[k] && prioArr[k] > prioArr[winner]) beaten = 1'b1;
  end

  // R4: a captured winner is eligible and outranked by nobody
  p_high_prio_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |-> (reqSync[winner] && !beaten));

  // R12: the grant does not move while a transfer is in flight
  p_grant_stable_r12: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active)) |-> $stable(chGrant));

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int FETCH_CLKS   = 4,
  parameter int DEPOSIT_CLKS = 4,
  parameter int SETTLE_CLKS  = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      anyElig,
  input  logic      holdReq,
  input  logic      busLock,
  input  xferMode_e curMode,
  input  logic      curDone,
  output ctlStb_t   ctl
);
  localparam int MAX_A = (FETCH_CLKS > DEPOSIT_CLKS) ? FETCH_CLKS : DEPOSIT_CLKS;
  localparam int MAX_C = (MAX_A > SETTLE_CLKS) ? MAX_A : SETTLE_CLKS;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] FETCH_LAST   = CNT_W'(FETCH_CLKS - 1);
  localparam logic [CNT_W-1:0] DEPOSIT_LAST = CNT_W'(DEPOSIT_CLKS - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST  = CNT_W'(SETTLE_CLKS - 1);

  seqState_e        state, nxtState;
  logic [CNT_W-1:0] cnt, nxtCnt;
  logic             blocked;
  logic             capture, flush;

  assign blocked = holdReq | busLock;

  always_comb begin
    nxtState = state;
    nxtCnt   = cnt;
    capture  = 1'b0;
    flush    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (anyElig && !blocked) begin
          nxtState = ST_PRIO;
          capture  = 1'b1;
        end
      end
      ST_PRIO: begin
        if (!blocked) begin
          nxtState = ST_FETCH;
          nxtCnt   = FETCH_LAST;
        end
      end
      ST_FETCH: begin
        if (cnt == '0) begin
          nxtState = ST_DEPOSIT;
          nxtCnt   = DEPOSIT_LAST;
        end else begin
          nxtCnt = cnt - CNT_W'(1);
        end
      end
      ST_DEPOSIT: begin
        if (cnt != '0) begin
          nxtCnt = cnt - CNT_W'(1);
        end else if (curMode == MODE_DST) begin
          nxtState = ST_SETTLE;
          nxtCnt   = SETTLE_LAST;
        end else if (curMode == MODE_FREE && !curDone) begin
          if (blocked) begin
            nxtState = ST_PRIO;
          end else begin
            nxtState = ST_FETCH;
            nxtCnt   = FETCH_LAST;
          end
        end else begin
          nxtState = ST_IDLE;
        end
      end
      ST_SETTLE: begin
        if (cnt == '0) begin
          nxtState = ST_IDLE;
          flush    = 1'b1;
        end else begin
          nxtCnt = cnt - CNT_W'(1);
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxtState;
      cnt   <= nxtCnt;
    end
  end

  assign ctl.capture = capture;
  assign ctl.flush   = flush;
  assign ctl.fetch   = (state == ST_FETCH);
  assign ctl.deposit = (state == ST_DEPOSIT);
  assign ctl.settle  = (state == ST_SETTLE);

  // R2: a fetch never begins right after a cycle with bus hold requested
  p_hold_defers_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.fetch) |-> !$past(holdReq));

  // R3: a fetch never begins right after a cycle with the bus locked
  p_lock_defers_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.fetch) |-> !$past(busLock));

  // R7: every fetch phase hands over directly to a deposit phase
  p_fetch_to_deposit_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctl.fetch) |-> ctl.deposit);

  // R8: settle clocks only follow a deposit, and only for destination pacing
  p_settle_after_deposit_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.settle) |-> $past(ctl.deposit));
  p_settle_dst_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.settle |-> (curMode == MODE_DST));

  // R11: a free-running channel whose count is reached does not fetch again
  p_done_stops_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ctl.deposit) && $past(curMode == MODE_FREE) && $past(curDone))
      |-> !ctl.fetch);

endmodule

// File: rtl/dma_req_sequencer.sv
module dma_req_sequencer
  import dma_seq_pkg::*;
#(
  parameter int NCH          = 2,
  parameter int PRIO_W       = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int FETCH_CLKS   = 4,
  parameter int DEPOSIT_CLKS = 4,
  parameter int SETTLE_CLKS  = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NCH-1:0]        chReq,
  input  logic [NCH*PRIO_W-1:0] chPrio,
  input  logic [2*NCH-1:0]      chMode,
  input  logic [NCH-1:0]        chDone,
  input  logic                  holdReq,
  input  logic                  busLock,
  input  logic                  byteBus,
  output logic                  fetchStb,
  output logic                  depositStb,
  output logic                  settleStb,
  output logic                  xferWord,
  output logic [NCH-1:0]        chGrant
);
  ctlStb_t   ctl;
  logic      anyElig;
  xferMode_e curMode;
  logic      curDone;

  dma_seq_ctrl #(
    .FETCH_CLKS  (FETCH_CLKS),
    .DEPOSIT_CLKS(DEPOSIT_CLKS),
    .SETTLE_CLKS (SETTLE_CLKS)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .anyElig(anyElig),
    .holdReq(holdReq),
    .busLock(busLock),
    .curMode(curMode),
    .curDone(curDone),
    .ctl    (ctl)
  );

  dma_seq_datapath #(
    .NCH        (NCH),
    .PRIO_W     (PRIO_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .chReq  (chReq),
    .chPrio (chPrio),
    .chMode (chMode),
    .chDone (chDone),
    .ctl    (ctl),
    .anyElig(anyElig),
    .curMode(curMode),
    .curDone(curDone),
    .chGrant(chGrant)
  );

  assign fetchStb   = ctl.fetch;
  assign depositStb = ctl.deposit;
  assign settleStb  = ctl.settle;
  assign xferWord   = (ctl.fetch | ctl.deposit) & ~byteBus;

  // R12: exactly one channel is granted whenever a bus phase is active
  p_grant_onehot_r12: assert property (@(posedge clk) disable iff (!rstN)
    (fetchStb | depositStb | settleStb) |-> $onehot(chGrant));

endmodule

// File: tb/test_dma_req_sequencer.sv
module test_dma_req_sequencer;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] chReq;
  logic [3:0] chPrio;
  logic [3:0] chMode;
  logic [1:0] chDone;
  logic       holdReq, busLock, byteBus;
  logic       fetchStb, depositStb, settleStb, xferWord;
  logic [1:0] chGrant;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dma_req_sequencer i_dma_req_sequencer (
    .clk(clk), .rstN(rstN), .chReq(chReq), .chPrio(chPrio), .chMode(chMode),
    .chDone(chDone), .holdReq(holdReq), .busLock(busLock), .byteBus(byteBus),
    .fetchStb(fetchStb), .depositStb(depositStb), .settleStb(settleStb),
    .xferWord(xferWord), .chGrant(chGrant)
  );

  // mode0, mode1, prio0, prio1, byteBus, first served, second served, settle clocks
  typedef struct packed {
    logic [1:0] m0, m1, p0, p1;
    logic       bb, expFirst, expSecond;
    logic [1:0] expSettle;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{2'd1, 2'd1, 2'd2, 2'd1, 1'b0, 1'b0, 1'b1, 2'd0},
    '{2'd1, 2'd1, 2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 2'd0},
    '{2'd1, 2'd1, 2'd1, 2'd1, 1'b0, 1'b1, 1'b0, 2'd0},
    '{2'd2, 2'd2, 2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 2'd2}
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic waitFetch(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!fetchStb && n < 100);
    if (!fetchStb) n = -1;
  endtask

  task automatic measure(output int f, output int d, output int s);
    f = 0; d = 0; s = 0;
    while (fetchStb)   begin f++; @(negedge clk); end
    while (depositStb) begin d++; @(negedge clk); end
    while (settleStb)  begin s++; @(negedge clk); end
  endtask

  function automatic int grantIdx();
    return chGrant[1] ? 1 : 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    int n, f, d, s, ch, bad, seen;
    rstN = 1'b0; chReq = '0; chPrio = '0; chMode = 4'h5; chDone = '0;
    holdReq = 1'b0; busLock = 1'b0; byteBus = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 strobes in reset", {fetchStb, depositStb, settleStb, xferWord, chGrant}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 strobes after reset", {fetchStb, depositStb, settleStb, xferWord, chGrant}, 0);

    // vector table: both channels request together
    for (int v = 0; v < 4; v++) begin
      chMode  = {VECS[v].m1, VECS[v].m0};
      chPrio  = {VECS[v].p1, VECS[v].p0};
      byteBus = VECS[v].bb;
      @(negedge clk);
      chReq = 2'b11;
      waitFetch(n);
      chk("R6 request to fetch latency", n, 4);
      ch = grantIdx();
      chk(VECS[v].p0 == VECS[v].p1 ? "R5 round-robin first" : "R4 priority first",
          ch, int'(VECS[v].expFirst));
      chk("R12 grant one-hot", $countones(chGrant), 1);
      chk("R9 word strobe", int'(xferWord), int'(!VECS[v].bb));
      chReq[ch] = 1'b0;
      measure(f, d, s);
      chk("R7 fetch clocks", f, 4);
      chk("R7 deposit clocks", d, 4);
      chk("R8 settle clocks", s, int'(VECS[v].expSettle));
      chk("R12 grant cleared", int'(chGrant), 0);
      waitFetch(n);
      ch = (n < 0) ? -1 : grantIdx();
      chk(VECS[v].p0 == VECS[v].p1 ? "R5 round-robin second" : "R4 lower waits",
          ch, int'(VECS[v].expSecond));
      if (ch >= 0) chReq[ch] = 1'b0;
      measure(f, d, s);
      chk("R8 settle clocks second", s, int'(VECS[v].expSettle));
      repeat (6) @(negedge clk);
    end
    byteBus = 1'b0;
    chMode  = 4'h5;
    chPrio  = 4'h0;

    // R2: bus hold keeps the request pending
    holdReq = 1'b1;
    chReq   = 2'b01;
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (fetchStb || chGrant != 0) bad++;
    end
    chk("R2 no cycle under hold", bad, 0);
    holdReq = 1'b0;
    waitFetch(n);
    chk("R2 start after hold release", n, 2);
    chReq = 2'b00;
    measure(f, d, s);
    repeat (4) @(negedge clk);

    // R3: bus lock keeps the request pending
    busLock = 1'b1;
    chReq   = 2'b10;
    bad = 0;
    repeat (30) begin
      @(negedge clk);
      if (fetchStb || chGrant != 0) bad++;
    end
    chk("R3 no cycle under lock", bad, 0);
    busLock = 1'b0;
    waitFetch(n);
    chk("R3 start after lock release", n, 2);
    chk("R12 grant for channel 1", int'(chGrant), 2);
    chReq = 2'b00;
    measure(f, d, s);
    repeat (4) @(negedge clk);

    // R11: free-running channel 0 chains until its count is reached
    chMode = 4'h4;  // ch0 free (0), ch1 source (1)
    chReq  = 2'b01;
    waitFetch(n);
    chReq = 2'b00;
    measure(f, d, s);
    chk("R11 back-to-back fetch", int'(fetchStb), 1);
    while (fetchStb) @(negedge clk);
    chDone = 2'b01;
    while (depositStb) @(negedge clk);
    chk("R11 stop on done", int'(fetchStb), 0);
    chk("R11 grant released", int'(chGrant), 0);
    chDone = 2'b00;
    seen = 0;
    repeat (10) begin
      @(negedge clk);
      if (fetchStb) seen++;
    end
    chk("R11 stays idle", seen, 0);

    // R10: destination-paced request seen only during deposit/settle is dropped
    chMode = 4'h6;  // ch0 destination (2), ch1 source (1)
    chReq  = 2'b01;
    waitFetch(n);
    measure(f, d, s);
    chk("R8 destination settle", s, 2);
    chReq = 2'b00;
    seen = 0;
    repeat (12) begin
      @(negedge clk);
      if (fetchStb) seen++;
    end
    chk("R10 stale request ignored", seen, 0);

    // R10: a request still high after settle starts a fresh transfer
    chReq = 2'b01;
    waitFetch(n);
    measure(f, d, s);
    waitFetch(n);
    chk("R10 resampled request latency", n, 4);
    chReq = 2'b00;
    measure(f, d, s);
    repeat (6) @(negedge clk);

    finishRun();
  end

endmodule